// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block lets several CPUs that share one small memory perform load-linked / store-conditional sequences. A CPU sends a load-exclusive to read a word and reserve it. Later it sends a store-exclusive to the same word. That store is written only if the CPU still holds the reservation, and the CPU gets back a one-bit status: 0 means the store succeeded, 1 means it failed. Plain loads and plain stores go through the same path.

The monitor keeps one reservation slot per CPU, holding a valid flag and a word index. A load-exclusive moves the reservation for that word to the CPU that issued it. Any store to the word drops the reservations on it. Because of this, a CPU that entered its sequence later can finish before one that entered earlier. Requests are served one per cycle. A fixed-priority arbiter, with the lowest index first, grants one pending request each cycle. The granted request completes at the next clock edge, and its response is presented for exactly one cycle.

Top module: `exmon_top`

## Requirements
- R1: A load-exclusive (op code 2) returns the addressed word on `respData` and records a reservation for the issuing CPU on that word.
- R2: A store-exclusive (op code 3) from a CPU whose reservation covers the addressed word writes the word and returns status 0.
- R3: A store-exclusive from a CPU whose reservation is absent or covers another word returns status 1 and leaves memory unchanged.
- R4: A load-exclusive by a second CPU to a reserved word clears the first holder's reservation and makes the second CPU the holder, so the first holder's store-exclusive then fails.
- R5: After any store-exclusive, every reservation on that word is gone, and so is the issuing CPU's own reservation, whether the store succeeded or failed.
- R6: A plain store (op code 1) always writes memory and clears every reservation on that word; a plain load (op code 0) changes no reservation.
- R7: Each CPU holds at most one reservation; a new load-exclusive from the same CPU replaces its previous one.
- R8: Address bits [1:0] are ignored, so reservations and memory are matched on the 4-byte word index taken from address bits [ADDR_W-1:2].
- R9: `reqGrant` is combinational, one-hot or zero, and goes to the lowest-indexed CPU with `reqValid` high; one request is served per cycle, and a CPU holds its request until it is granted.
- R10: A request granted in a cycle gives `respValid` equal to that grant in the next cycle only. `respData` carries the word as it was before the operation for loads and 0 for stores. `respStatus` is 0 for every op except a failed store-exclusive.
- R11: After reset, memory reads zero, no reservation is held, and `respValid` and `reqGrant` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | N_CPU | Per-CPU request pending |
| reqOp | input | 2*N_CPU | Per-CPU op: 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| reqAddr | input | N_CPU*ADDR_W | Per-CPU byte address |
| reqWdata | input | N_CPU*DATA_W | Per-CPU store data |
| reqGrant | output | N_CPU | Combinational one-hot grant |
| respValid | output | N_CPU | One-hot response strobe, one cycle after grant |
| respData | output | DATA_W | Load data (0 for stores) |
| respStatus | output | 1 | 1 when a store-exclusive failed |

## Verification
`reqGrant` is a combinational result, so the bench checks it one time unit after it drives a request at a falling edge. Memory, the reservations and the response registers all update at the next rising edge. The response is therefore checked at the falling edge that follows, one full cycle after the request was driven, and the bench withdraws the granted request at that same edge. When several CPUs request in the same cycle, the bench checks the next grant at each falling edge and the response to the previous grant at the same edge, one grant and one response per cycle.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_LOADX  = 2'd2,
    OP_STOREX = 2'd3
  } memOpE;

  typedef struct packed {
    logic act;
    logic wrEn;
    logic rdEn;
    logic status;
  } exStrobeT;

endpackage

// File: rtl/exmon_ctrl.sv
module exmon_ctrl
  import exmon_pkg::*;
#(
  parameter int N_CPU  = 3,
  parameter int WORD_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [N_CPU-1:0]          reqValid,
  input  logic [2*N_CPU-1:0]        reqOp,
  input  logic [N_CPU*WORD_W-1:0]   reqWord,
  output logic [N_CPU-1:0]          reqGrant,
  output exStrobeT                  strb
);

  logic [N_CPU-1:0]             resValid;
  logic [N_CPU-1:0][WORD_W-1:0] resWord;
  logic                         found;
  memOpE                        selOp;
  logic [WORD_W-1:0]            selWord;
  logic [N_CPU-1:0]             wordHit;
  logic                         holds;

  // Fixed-priority arbiter: lowest index wins
  always_comb begin
    reqGrant = '0;
    found    = 1'b0;
    for (int i = 0; i < N_CPU; i++) begin
      if (reqValid[i] && !found) begin
        reqGrant[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  // Select the granted request
  always_comb begin
    selOp   = OP_LOAD;
    selWord = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (reqGrant[i]) begin
        selOp   = memOpE'(reqOp[2*i +: 2]);
        selWord = reqWord[i*WORD_W +: WORD_W];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_CPU; i++) begin
      wordHit[i] = resValid[i] && (resWord[i] == selWord);
    end
  end

  assign holds = |(reqGrant & wordHit);

  always_comb begin
    strb.act    = found;
    strb.wrEn   = found && ((selOp == OP_STORE) || (selOp == OP_STOREX && holds));
    strb.rdEn   = found && ((selOp == OP_LOAD) || (selOp == OP_LOADX));
    strb.status = found && (selOp == OP_STOREX) && !holds;
  end

  // Reservation table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= '0;
      resWord  <= '0;
    end else if (found) begin
      for (int i = 0; i < N_CPU; i++) begin
        unique case (selOp)
          OP_LOADX: begin
            if (reqGrant[i]) begin
              resValid[i] <= 1'b1;
              resWord[i]  <= selWord;
            end else if (wordHit[i]) begin
              resValid[i] <= 1'b0;
            end
          end
          OP_STORE: if (wordHit[i]) resValid[i] <= 1'b0;
          OP_STOREX: if (reqGrant[i] || wordHit[i]) resValid[i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/exmon_dp.sv
module exmon_dp
  import exmon_pkg::*;
#(
  parameter int N_CPU  = 3,
  parameter int WORD_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  exStrobeT                 strb,
  input  logic [N_CPU-1:0]         reqGrant,
  input  logic [N_CPU*WORD_W-1:0]  reqWord,
  input  logic [N_CPU*DATA_W-1:0]  reqWdata,
  output logic [N_CPU-1:0]         respValid,
  output logic [DATA_W-1:0]        respData,
  output logic                     respStatus
);

  localparam int DEPTH = 1 << WORD_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] selWord;
  logic [DATA_W-1:0] selData;

  always_comb begin
    selWord = '0;
    selData = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (reqGrant[i]) begin
        selWord = reqWord[i*WORD_W +: WORD_W];
        selData = reqWdata[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) memArr[k] <= '0;
    end else if (strb.wrEn) begin
      memArr[selWord] <= selData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= '0;
      respData   <= '0;
      respStatus <= 1'b0;
    end else begin
      respValid  <= strb.act ? reqGrant : '0;
      respData   <= strb.rdEn ? memArr[selWord] : '0;
      respStatus <= strb.status;
    end
  end

endmodule

// File: rtl/exmon_top.sv
module exmon_top
  import exmon_pkg::*;
#(
  parameter int N_CPU  = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [N_CPU-1:0]         reqValid,
  input  logic [2*N_CPU-1:0]       reqOp,
  input  logic [N_CPU*ADDR_W-1:0]  reqAddr,
  input  logic [N_CPU*DATA_W-1:0]  reqWdata,
  output logic [N_CPU-1:0]         reqGrant,
  output logic [N_CPU-1:0]         respValid,
  output logic [DATA_W-1:0]        respData,
  output logic                     respStatus
);

  localparam int WORD_W = ADDR_W - 2;

  logic [N_CPU*WORD_W-1:0] reqWord;
  logic [2*N_CPU-1:0]      unusedOffsets;
  exStrobeT                strb;

  // Word granularity: drop the byte offset of each address
  for (genvar g = 0; g < N_CPU; g++) begin : gWord
    assign reqWord[g*WORD_W +: WORD_W] = reqAddr[g*ADDR_W + 2 +: WORD_W];
    assign unusedOffsets[2*g +: 2]     = reqAddr[g*ADDR_W +: 2];
  end

  exmon_ctrl #(.N_CPU(N_CPU), .WORD_W(WORD_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqWord  (reqWord),
    .reqGrant (reqGrant),
    .strb     (strb)
  );

  exmon_dp #(.N_CPU(N_CPU), .WORD_W(WORD_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqGrant   (reqGrant),
    .reqWord    (reqWord),
    .reqWdata   (reqWdata),
    .respValid  (respValid),
    .respData   (respData),
    .respStatus (respStatus)
  );

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
  parameter int N_CPU  = 3,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [N_CPU-1:0]     reqValid,
  input logic [2*N_CPU-1:0]   reqOp,
  input logic [N_CPU-1:0]     reqGrant,
  input logic [N_CPU-1:0]     respValid,
  input logic [DATA_W-1:0]    respData,
  input logic                 respStatus
);

  logic grantStx;
  logic grantStore;

  always_comb begin
    grantStx   = 1'b0;
    grantStore = 1'b0;
    for (int i = 0; i < N_CPU; i++) begin
      if (reqGrant[i] && reqOp[2*i +: 2] == 2'd3) grantStx = 1'b1;
      if (reqGrant[i] && reqOp[2*i] == 1'b1) grantStore = 1'b1;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant)); // R9
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0); // R9
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> reqGrant[0]); // R9
  AST_RESP_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (|reqGrant) |=> (respValid == $past(reqGrant))); // R10
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !(|reqGrant) |=> (respValid == '0)); // R10
  AST_FAIL_ONLY_STX: assert property (@(posedge clk) disable iff (!rstN)
    !grantStx |=> !respStatus); // R3
  AST_STORE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    grantStore |=> (respData == '0)); // R10

endmodule

bind exmon_top exmon_chk #(.N_CPU(N_CPU), .DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .reqGrant   (reqGrant),
  .respValid  (respValid),
  .respData   (respData),
  .respStatus (respStatus)
);

// File: tb/tb_exmon_top.sv
`timescale 1ns/1ps
module tb_exmon_top;

  localparam int N  = 3;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    reqValid = '0;
  logic [2*N-1:0]  reqOp = '0;
  logic [N*AW-1:0] reqAddr = '0;
  logic [N*DW-1:0] reqWdata = '0;
  logic [N-1:0]    reqGrant;
  logic [N-1:0]    respValid;
  logic [DW-1:0]   respData;
  logic            respStatus;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mMem [NW];
  bit            mResV [N];
  int            mResW [N];

  exmon_top #(.N_CPU(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqGrant(reqGrant),
    .respValid(respValid), .respData(respData), .respStatus(respStatus)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic modelOp(int cpu, int op, int addr, int wd,
                         output int ed, output int es);
    int  w;
    bit  holds;
    w     = (addr >> 2) % NW;
    holds = mResV[cpu] && (mResW[cpu] == w);
    ed    = (op == 0 || op == 2) ? int'(mMem[w]) : 0;
    es    = (op == 3 && !holds) ? 1 : 0;
    if (op == 1 || (op == 3 && holds)) mMem[w] = DW'(wd);
    for (int i = 0; i < N; i++) begin
      bit hit;
      hit = mResV[i] && (mResW[i] == w);
      case (op)
        2: if (i == cpu) begin mResV[i] = 1; mResW[i] = w; end
           else if (hit) mResV[i] = 0;
        1: if (hit) mResV[i] = 0;
        3: if (i == cpu || hit) mResV[i] = 0;
        default: ;
      endcase
    end
  endtask

  task automatic drive(int cpu, int op, int addr, int wd);
    reqValid[cpu]          = 1'b1;
    reqOp[2*cpu +: 2]      = 2'(op);
    reqAddr[cpu*AW +: AW]  = AW'(addr);
    reqWdata[cpu*DW +: DW] = DW'(wd);
  endtask

  task automatic issue(int cpu, int op, int addr, int wd, string req);
    int ed, es;
    @(negedge clk);
    drive(cpu, op, addr, wd);
    #1;
    chk(reqGrant == N'(1 << cpu), "R9", "grant", int'(reqGrant), 1 << cpu);
    modelOp(cpu, op, addr, wd, ed, es);
    @(negedge clk);
    reqValid[cpu] = 1'b0;
    chk(respValid == N'(1 << cpu), "R10", "respValid", int'(respValid), 1 << cpu);
    chk(int'(respData) == ed, req, "respData", int'(respData), ed);
    chk(int'(respStatus) == es, req, "respStatus", int'(respStatus), es);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NW; k++) mMem[k] = '0;
    for (int i = 0; i < N; i++) begin mResV[i] = 0; mResW[i] = 0; end
    repeat (4) @(negedge clk);
    chk(respValid == '0, "R11", "respValid in reset", int'(respValid), 0);
    rstN = 1'b1;
    #1;
    chk(reqGrant == '0, "R11", "idle grant", int'(reqGrant), 0);
    chk(respValid == '0, "R11", "idle respValid", int'(respValid), 0);

    // R11: memory zero after reset; R3: no reservation after reset
    for (int w = 0; w < NW; w++) issue(w % N, 0, w * 4, 0, "R11");
    for (int c = 0; c < N; c++) issue(c, 3, c * 4, 16'hDEAD, "R3");
    issue(0, 0, 0, 0, "R3");

    // Sweep: reserve, steal, fail, succeed, clear, read back (R1 R2 R4 R5 R8)
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a == b) continue;
        for (int w = 0; w < NW; w++) begin
          int d;
          d = (w * 37 + a * 5 + b * 11 + 1) & 16'hFFFF;
          issue(a, 2, w * 4, 0, "R1");
          issue(b, 2, w * 4 + ((w + a) % 4), 0, "R8");
          issue(a, 3, w * 4, d + 1, "R4");
          issue(b, 3, w * 4 + (b % 4), d, "R2");
          issue(b, 3, w * 4, d + 2, "R5");
          issue(a, 0, w * 4 + 3, 0, "R1");
        end
      end
    end

    // R3: reservation on another word fails, R5: own reservation dropped
    issue(1, 2, 8, 0, "R1");
    issue(1, 3, 12, 16'h1111, "R3");
    issue(1, 3, 8, 16'h2222, "R5");
    issue(0, 0, 12, 0, "R3");
    issue(0, 0, 8, 0, "R3");

    // R6: plain store clears reservation; plain load does not
    issue(2, 2, 20, 0, "R1");
    issue(0, 0, 20, 0, "R6");
    issue(2, 3, 20, 16'h3333, "R6");
    issue(2, 2, 24, 0, "R1");
    issue(1, 1, 24, 16'h4444, "R6");
    issue(2, 3, 24, 16'h5555, "R6");
    issue(0, 0, 24, 0, "R6");

    // R7: second load-exclusive replaces the first
    issue(0, 2, 32, 0, "R7");
    issue(0, 2, 36, 0, "R7");
    issue(0, 3, 32, 16'h6666, "R7");
    issue(0, 2, 32, 0, "R7");
    issue(0, 2, 36, 0, "R7");
    issue(0, 3, 36, 16'h7777, "R7");
    issue(1, 0, 36, 0, "R7");

    // R9: simultaneous requests served in index order, later one wins
    @(negedge clk);
    for (int c = 0; c < N; c++) drive(c, 2, 40, 0);
    for (int k = 0; k < N; k++) begin
      int ed, es;
      #1;
      chk(reqGrant == N'(1 << k), "R9", "ordered grant", int'(reqGrant), 1 << k);
      modelOp(k, 2, 40, 0, ed, es);
      @(negedge clk);
      reqValid[k] = 1'b0;
      chk(respValid == N'(1 << k), "R9", "ordered resp", int'(respValid), 1 << k);
      chk(int'(respData) == ed, "R9", "ordered data", int'(respData), ed);
    end
    @(negedge clk);
    for (int c = 0; c < N; c++) drive(c, 3, 40, 16'h0A00 + c);
    for (int k = 0; k < N; k++) begin
      int ed, es;
      #1;
      chk(reqGrant == N'(1 << k), "R9", "ordered stx grant", int'(reqGrant), 1 << k);
      modelOp(k, 3, 40, 16'h0A00 + k, ed, es);
      @(negedge clk);
      reqValid[k] = 1'b0;
      chk(int'(respStatus) == es, "R4", "late entrant status", int'(respStatus), es);
    end
    issue(0, 0, 40, 0, "R4");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule